// File: doc/BRIEF.md
# Trigger window watchdog with hysteresis

This block watches a periodic trigger from a host processor. It measures the time between rising edges of that trigger, counting ticks of a slow time-base enable. Each rising edge is rated good if it lands inside a timing window and bad if it lands too early or too late. A saturating two-bit health level climbs on good edges and falls on bad ones. The health output `wd_ok` turns on only when the level reaches its top value. It turns off only when the level drains to zero, so the host must deliver three good triggers in a row before it is trusted.

The window edges depend on the current health state. While `wd_ok` is high the window is one tick wider on each side, and this gives hysteresis at both edges. A trigger that stops altogether is caught without waiting for another edge: once the dropout limit of ticks passes, the level and `wd_ok` clear at once. An oscillator-error input, raised when the time base has stopped, also forces the block into the unhealthy state. A synchronous reset, driven from power-on or supply-fault detection, returns the block to its initial state.

Top module: `trig_window_wd`

## Requirements
- R1: After `rst` is applied, `dbg_level` is 0, `wd_ok` is 0 and `dbg_ticks` is 0.
- R2: `dbg_ticks` counts the cycles in which `tb_tick` is high, and it returns to 0 when a trigger rising edge is processed.
- R3: While `wd_ok` is 0, an edge is good only if the tick count at that edge is greater than 80 and less than 169. A good edge raises `dbg_level` by one and a bad edge lowers it by one.
- R4: `dbg_level` does not go above 3 or below 0. A good edge at level 3 leaves it at 3, and a bad edge at level 0 leaves it at 0.
- R5: `wd_ok` rises only when `dbg_level` becomes 3. At levels 1 and 2 it keeps its previous value.
- R6: `wd_ok` falls when `dbg_level` becomes 0.
- R7: While `wd_ok` is 1, an edge is good only if the tick count is greater than 79 and less than 170. So counts 80 and 169 are good, and counts 79 and 170 are bad.
- R8: When `dbg_ticks` reaches 250 with no trigger edge, `dbg_level` and `wd_ok` both clear in that same update. After that, `dbg_ticks` holds at 250.
- R9: While `osc_err` is high, `dbg_level` is cleared to 0 and `wd_ok` is held at 0.
- R10: `trig_in` passes through two synchroniser flops before edge detection. When an edge and a tick are processed in the same cycle, the edge is rated on the count before that tick, and the count then becomes 0.
- R11: A falling edge of `trig_in`, or holding it high, does not change `dbg_level`, `wd_ok` or `dbg_ticks`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_tick | input | 1 | One-cycle time-base enable pulse |
| trig_in | input | 1 | Asynchronous trigger from the host |
| osc_err | input | 1 | Time-base failure indication, active high |
| wd_ok | output | 1 | Host healthy |
| dbg_level | output | 2 | Current health level, 0 to 3 |
| dbg_ticks | output | TW (8) | Ticks since the last trigger edge |

## Verification
The bench aims at the exact window boundaries in both health states: counts 79, 80, 169 and 170 with `wd_ok` high, and 80, 81, 168 and 169 with it low. A design with a fixed window, or with the hysteresis reversed, rates one of these the wrong way. It also lets the level fall back to 2 and 1 while healthy, to catch a `wd_ok` that follows every level change instead of holding. It drives ticks one short of the dropout limit and then the final tick, which exposes a clear that fires one tick early or late. It also places a tick in the same cycle as an edge, so a design that counts the tick before rating the edge moves the level the wrong way.

// File: rtl/trig_window_wd.sv
module trig_window_wd #(
  parameter int WIN_LO_OK  = 79,
  parameter int WIN_LO_FLT = 80,
  parameter int WIN_HI_OK  = 170,
  parameter int WIN_HI_FLT = 169,
  parameter int DROP_TICKS = 250,
  localparam int TW = $clog2(DROP_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tb_tick,
  input  logic          trig_in,
  input  logic          osc_err,
  output logic          wd_ok,
  output logic [1:0]    dbg_level,
  output logic [TW-1:0] dbg_ticks
);

  localparam logic [TW-1:0] LO_OK  = TW'(WIN_LO_OK);
  localparam logic [TW-1:0] LO_FLT = TW'(WIN_LO_FLT);
  localparam logic [TW-1:0] HI_OK  = TW'(WIN_HI_OK);
  localparam logic [TW-1:0] HI_FLT = TW'(WIN_HI_FLT);
  localparam logic [TW-1:0] DROP   = TW'(DROP_TICKS);

  logic [2:0]    sync_q;
  logic [TW-1:0] ticks;
  logic [1:0]    level;
  logic          ok;

  wire           rise    = sync_q[1] & ~sync_q[2];
  wire [TW-1:0]  lo_lim  = ok ? LO_OK : LO_FLT;
  wire [TW-1:0]  hi_lim  = ok ? HI_OK : HI_FLT;
  wire           in_win  = (ticks > lo_lim) && (ticks < hi_lim);
  wire [1:0]     lvl_up  = (level == 2'd3) ? 2'd3 : level + 2'd1;
  wire [1:0]     lvl_dn  = (level == 2'd0) ? 2'd0 : level - 2'd1;
  wire [1:0]     lvl_new = in_win ? lvl_up : lvl_dn;
  wire           dropout = tb_tick && !rise && (ticks == DROP - TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      ticks  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], trig_in};
      if (rise)
        ticks <= '0;
      else if (tb_tick && ticks != DROP)
        ticks <= ticks + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || osc_err || dropout) begin
      level <= 2'd0;
      ok    <= 1'b0;
    end else if (rise) begin
      level <= lvl_new;
      if (lvl_new == 2'd3)
        ok <= 1'b1;
      else if (lvl_new == 2'd0)
        ok <= 1'b0;
    end
  end

  assign wd_ok     = ok;
  assign dbg_level = level;
  assign dbg_ticks = ticks;

endmodule

module trig_window_wd_chk #(
  parameter int TW = 8,
  parameter int DROP_TICKS = 250
) (
  input logic          clk,
  input logic          rst,
  input logic          osc_err,
  input logic          wd_ok,
  input logic [1:0]    dbg_level,
  input logic [TW-1:0] dbg_ticks
);

  assert_ok_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_ok) |-> dbg_level == 2'd3);

  assert_ok_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (dbg_level == 2'd1 || dbg_level == 2'd2) |-> $stable(wd_ok));

  assert_ok_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_ok) |-> dbg_level == 2'd0);

  assert_level_step_R4: assert property (@(posedge clk) disable iff (rst)
    (dbg_level != $past(dbg_level) && dbg_level != 2'd0) |->
      (dbg_level == $past(dbg_level) + 2'd1 || dbg_level == $past(dbg_level) - 2'd1));

  assert_osc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    osc_err |=> (dbg_level == 2'd0 && !wd_ok));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_ticks <= TW'(DROP_TICKS));

  assert_dropout_R8: assert property (@(posedge clk) disable iff (rst)
    (dbg_ticks == TW'(DROP_TICKS)) |-> (dbg_level == 2'd0 && !wd_ok));

endmodule

bind trig_window_wd trig_window_wd_chk #(.TW(TW), .DROP_TICKS(DROP_TICKS)) u_chk (
  .clk(clk), .rst(rst), .osc_err(osc_err), .wd_ok(wd_ok),
  .dbg_level(dbg_level), .dbg_ticks(dbg_ticks)
);

// File: tb/trig_window_wd_bench.sv
`timescale 1ns/1ps
module trig_window_wd_bench;
  localparam int DROP = 250;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tb_tick = 1'b0;
  logic trig_in = 1'b0;
  logic osc_err = 1'b0;
  logic wd_ok;
  logic [1:0] dbg_level;
  logic [7:0] dbg_ticks;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  trig_window_wd u_trig_window_wd (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .trig_in(trig_in),
    .osc_err(osc_err), .wd_ok(wd_ok), .dbg_level(dbg_level), .dbg_ticks(dbg_ticks)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int lvl, input int ok);
    chk({tag, " level"}, dbg_level, lvl);
    chk({tag, " wd_ok"}, wd_ok, ok);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tb_tick = 1'b1; @(negedge clk);
      tb_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic trig_rise;
    trig_in = 1'b1; repeat (3) @(negedge clk);
  endtask

  task automatic trig_fall;
    trig_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic period(input int n);
    ticks(n); trig_rise(); trig_fall();
  endtask

  task automatic do_reset;
    rst = 1'b1; tb_tick = 1'b0; trig_in = 1'b0; osc_err = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    chk_state("R1 after reset", 0, 0);
    chk("R1 ticks after reset", dbg_ticks, 0);
  endtask

  task automatic t_count;
    ticks(37);
    chk("R2 ticks counted", dbg_ticks, 37);
    trig_rise();
    chk("R2 ticks cleared by edge", dbg_ticks, 0);
    trig_fall();
    chk_state("R3 count 37 bad at level 0", 0, 0);
  endtask

  task automatic t_climb;
    period(100); chk_state("R3 good 100", 1, 0);
    period(168); chk_state("R3 good 168 while low", 2, 0);
    period(81);  chk_state("R5 good 81 reaches 3", 3, 1);
    period(100); chk_state("R4 saturate at 3", 3, 1);
  endtask

  task automatic t_hyst_ok;
    period(170); chk_state("R7 170 bad while ok, R5 hold", 2, 1);
    period(80);  chk_state("R7 80 good while ok", 3, 1);
    period(169); chk_state("R7 169 good while ok", 3, 1);
    period(79);  chk_state("R7 79 bad while ok", 2, 1);
  endtask

  task automatic t_drain;
    period(10); chk_state("R5 level 1 holds ok", 1, 1);
    period(10); chk_state("R6 level 0 clears ok", 0, 0);
    period(10); chk_state("R4 saturate at 0", 0, 0);
  endtask

  task automatic t_hyst_flt;
    period(100); chk_state("R3 setup", 1, 0);
    period(80);  chk_state("R3 80 bad while low", 0, 0);
    period(100); chk_state("R3 setup 2", 1, 0);
    period(169); chk_state("R3 169 bad while low", 0, 0);
  endtask

  task automatic t_same_cycle;
    period(100); chk_state("R10 setup", 1, 0);
    ticks(80);
    trig_in = 1'b1; repeat (2) @(negedge clk);
    tb_tick = 1'b1; @(negedge clk);
    tb_tick = 1'b0;
    chk_state("R10 edge rated before coincident tick", 0, 0);
    chk("R10 count zero after coincident edge", dbg_ticks, 0);
    trig_fall();
    chk("R10 stays zero", dbg_ticks, 0);
  endtask

  task automatic t_level_trig;
    ticks(100); trig_rise();
    chk_state("R11 edge processed", 1, 0);
    ticks(50);
    chk_state("R11 held high no effect", 1, 0);
    chk("R11 ticks run while high", dbg_ticks, 50);
    trig_fall();
    chk_state("R11 falling edge no effect", 1, 0);
    chk("R11 ticks kept on fall", dbg_ticks, 50);
  endtask

  task automatic t_dropout;
    period(100); period(100);
    chk_state("R8 setup healthy", 3, 1);
    ticks(DROP - 1);
    chk_state("R8 one short of limit", 3, 1);
    ticks(1);
    chk_state("R8 cleared at limit", 0, 0);
    chk("R8 ticks at limit", dbg_ticks, DROP);
    ticks(5);
    chk("R8 ticks saturate", dbg_ticks, DROP);
  endtask

  task automatic t_osc;
    period(0); period(100); period(100); period(100);
    chk_state("R9 setup healthy", 3, 1);
    osc_err = 1'b1; @(negedge clk);
    chk_state("R9 osc error clears", 0, 0);
    ticks(100); trig_rise(); trig_fall();
    chk_state("R9 good edge ignored during osc error", 0, 0);
    osc_err = 1'b0; @(negedge clk);
    period(100);
    chk_state("R9 resumes after osc error", 1, 0);
  endtask

  task automatic t_reset_mid;
    period(100);
    do_reset();
    chk_state("R1 reset mid run", 0, 0);
    chk("R1 ticks mid run", dbg_ticks, 0);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_count();
    t_climb();
    t_hyst_ok();
    t_drain();
    t_hyst_flt();
    t_same_cycle();
    t_level_trig();
    t_dropout();
    t_osc();
    t_reset_mid();
    report();
  end
endmodule